// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block turns a programmed mode word and a stream of read/write commands into the per-clock column addresses of an SDRAM burst. A mode-load strobe presents a 13-bit word. The block decodes the burst length, the burst ordering, the CAS latency and the write-burst option from that word, and keeps the word only if every field holds a supported code. Each command carries a starting column. Starting on the cycle after the command, the block presents one column per clock, flags the final beat of a fixed-length burst, and then goes idle.

Bursts of 2, 4 or 8 stay inside the aligned block that holds the starting column. The order within the block is either an incrementing wrap or a bitwise XOR of the start offset with the beat number. A full-page burst increments across the whole row, wraps at the row end and does not stop by itself. It ends on the terminate input or on a new command. The column width is a parameter, so one block serves several device organisations. Command decoding, bank and row handling, refresh and data movement are handled elsewhere.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, col_vld, col_last and mode_err are 0 and cas_lat is 2. The mode in effect is burst length 1, sequential order, and writes use the programmed length.
- R2: Mode bits [2:0] select the burst length: 000 gives 1 beat, 001 gives 2, 010 gives 4 and 011 gives 8. Code 111 gives a full-page burst when bit 3 is 0.
- R3: With bit 3 = 0 and a fixed length L, beat i addresses the column whose low log2(L) bits are (start + i) mod L. The bits above those stay equal to the start column's bits for the whole burst (start 5, L = 8 gives 5,6,7,0,1,2,3,4).
- R4: With bit 3 = 1 and a fixed length L, beat i addresses the column whose low log2(L) bits are (start XOR i). The upper bits are kept (start 5, L = 8 gives 5,4,7,6,1,0,3,2).
- R5: With burst length 1, a command yields exactly one beat at the start column with col_last = 1. Bit 3 has no effect.
- R6: A full-page burst presents start, start+1, ... modulo 2^COL_W, never raises col_last, and continues until terminate or a new command.
- R7: Mode bits [6:4] = 010 give cas_lat 2 and 011 give cas_lat 3. After a valid load the new value shows on cas_lat from the next cycle.
- R8: A load is rejected when it has any of these: length code 100, 101 or 110; code 111 with bit 3 = 1; a latency code other than 010 or 011; or bits [8:7] not 00. A rejected load sets mode_err on the next cycle and leaves every previous setting in effect. A valid load clears mode_err. Bits [12:10] are ignored.
- R9: With mode bit 9 = 1, a write command (cmd_wr = 1) yields a single beat at the start column. A read command still uses the programmed length and order.
- R10: A command that arrives during a burst aborts it. The next cycle shows beat 0 of the new burst.
- R11: burst_term high while a burst is active makes col_vld 0 on the next cycle. When a command arrives in the same cycle, the command wins. While idle, burst_term has no effect.
- R12: col_last is 1 exactly on the final beat of a fixed-length burst. col_vld is 0 on the following cycle unless a new command arrived.
- R13: The length, order and write option are captured when a command is accepted. A mode load in the same cycle as the command, or during the burst, does not alter that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_ld | input | 1 | Load strobe for mode_word |
| mode_word | input | 13 | Mode word: [2:0] length, [3] order, [6:4] latency, [8:7] op mode, [9] write option |
| cmd_vld | input | 1 | Command strobe: start a burst |
| cmd_wr | input | 1 | 1 = write command, 0 = read command |
| cmd_col | input | COL_W | Starting column of the command |
| burst_term | input | 1 | Ends the active burst |
| col_addr | output | COL_W | Current column address |
| col_vld | output | 1 | col_addr is a burst beat |
| col_last | output | 1 | Final beat of a fixed-length burst |
| mode_err | output | 1 | Last mode load was rejected |
| cas_lat | output | 2 | CAS latency in effect (2 or 3) |

## Verification
A mode load and a command can fall in the same clock cycle. The bench issues both together, and also loads a new mode halfway through a burst. The cycle-level model applies the command with the settings held before the load, so any leak of the new length or order into that burst shows up as a beat mismatch. The same-cycle meeting of burst_term with a new command is also driven. There the model expects beat 0 of the new burst on the following cycle rather than an idle output.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

   // burst kinds held once a mode word is accepted
   typedef enum logic [2:0] {
      BK_ONE   = 3'd0,
      BK_TWO   = 3'd1,
      BK_FOUR  = 3'd2,
      BK_EIGHT = 3'd3,
      BK_PAGE  = 3'd4
   } bk_e;

   // log2 of the block size for fixed kinds
   function automatic logic [4:0] bk_log2(input bk_e k);
      case (k)
         BK_TWO:   bk_log2 = 5'd1;
         BK_FOUR:  bk_log2 = 5'd2;
         BK_EIGHT: bk_log2 = 5'd3;
         default:  bk_log2 = 5'd0;
      endcase
   endfunction

endpackage

// File: rtl/bcs_mode_reg.sv
module bcs_mode_reg
   import bcs_pkg::*;
#(
   parameter int MW = 13
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld,
   input  logic [MW-1:0] word,
   output bk_e           kind,
   output logic          ilv,
   output logic          wr_single,
   output logic          cl3,
   output logic          err
);

   if (MW < 10) begin : g_mw_chk
      $error("bcs_mode_reg: MW must cover bits up to 9");
   end

   bk_e  cand_kind;
   logic cand_cl3;
   logic ok;
   logic unused_rsvd;

   assign unused_rsvd = ^word[MW-1:10];

   always_comb begin
      ok        = 1'b1;
      cand_kind = BK_ONE;
      cand_cl3  = 1'b0;
      case (word[2:0])
         3'b000: cand_kind = BK_ONE;
         3'b001: cand_kind = BK_TWO;
         3'b010: cand_kind = BK_FOUR;
         3'b011: cand_kind = BK_EIGHT;
         3'b111: begin
            cand_kind = BK_PAGE;
            if (word[3]) ok = 1'b0;
         end
         default: ok = 1'b0;
      endcase
      case (word[6:4])
         3'b010:  cand_cl3 = 1'b0;
         3'b011:  cand_cl3 = 1'b1;
         default: ok = 1'b0;
      endcase
      if (word[8:7] != 2'b00) ok = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind      <= BK_ONE;
         ilv       <= 1'b0;
         wr_single <= 1'b0;
         cl3       <= 1'b0;
         err       <= 1'b0;
      end else if (ld) begin
         err <= !ok;
         if (ok) begin
            kind      <= cand_kind;
            ilv       <= word[3];
            wr_single <= word[9];
            cl3       <= cand_cl3;
         end
      end
   end

   // R8
   rejected_keeps_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld && !ok |=> $stable(kind) && $stable(ilv) && $stable(wr_single) && $stable(cl3));

   // R6
   page_never_ilv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      kind == BK_PAGE |-> !ilv);

endmodule

// File: rtl/bcs_beat_ctrl.sv
module bcs_beat_ctrl
   import bcs_pkg::*;
#(
   parameter int COL_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_vld,
   input  logic             cmd_wr,
   input  logic [COL_W-1:0] cmd_col,
   input  logic             term,
   input  bk_e              mode_kind,
   input  logic             mode_ilv,
   input  logic             mode_wr_single,
   output logic             active,
   output logic             last,
   output logic [COL_W-1:0] start_q,
   output logic [COL_W-1:0] beat_q,
   output bk_e              kind_q,
   output logic             ilv_q
);

   logic [COL_W-1:0] len_m1;

   always_comb begin
      case (kind_q)
         BK_TWO:   len_m1 = COL_W'(1);
         BK_FOUR:  len_m1 = COL_W'(3);
         BK_EIGHT: len_m1 = COL_W'(7);
         default:  len_m1 = '0;
      endcase
   end

   assign last = active && (kind_q != BK_PAGE) && (beat_q == len_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active  <= 1'b0;
         start_q <= '0;
         beat_q  <= '0;
         kind_q  <= BK_ONE;
         ilv_q   <= 1'b0;
      end else if (cmd_vld) begin
         active  <= 1'b1;
         start_q <= cmd_col;
         beat_q  <= '0;
         kind_q  <= (cmd_wr && mode_wr_single) ? BK_ONE : mode_kind;
         ilv_q   <= mode_ilv;
      end else if (active) begin
         if (term || last) begin
            active <= 1'b0;
         end else begin
            beat_q <= beat_q + COL_W'(1);
         end
      end
   end

   // R10
   cmd_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_vld |=> active && beat_q == '0 && start_q == $past(cmd_col));

   // R11
   term_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      term && !cmd_vld |=> !active);

   // R12
   last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
      last && !cmd_vld |=> !active);

   // R13
   burst_mode_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active && !cmd_vld |=> $stable(kind_q) && $stable(ilv_q) && $stable(start_q));

endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen
   import bcs_pkg::*;
#(
   parameter int COL_W = 10
) (
   input  logic [COL_W-1:0] start,
   input  logic [COL_W-1:0] beat,
   input  bk_e              kind,
   input  logic             ilv,
   output logic [COL_W-1:0] col
);

   logic [COL_W-1:0] in_blk;
   logic [COL_W-1:0] sum;
   logic [4:0]       lg;
   logic             page;
   logic             xor_mode;

   assign lg       = bk_log2(kind);
   assign page     = (kind == BK_PAGE);
   assign xor_mode = ilv && !page;
   assign sum      = start + beat;

   for (genvar b = 0; b < COL_W; b++) begin : g_bit
      assign in_blk[b] = page || (lg > 5'(b));
      assign col[b]    = !in_blk[b] ? start[b]
                       : (xor_mode ? (start[b] ^ beat[b]) : sum[b]);
   end

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
   import bcs_pkg::*;
#(
   parameter int COL_W  = 10,
   parameter int MODE_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_ld,
   input  logic [MODE_W-1:0] mode_word,
   input  logic              cmd_vld,
   input  logic              cmd_wr,
   input  logic [COL_W-1:0]  cmd_col,
   input  logic              burst_term,
   output logic [COL_W-1:0]  col_addr,
   output logic              col_vld,
   output logic              col_last,
   output logic              mode_err,
   output logic [1:0]        cas_lat
);

   localparam int BLK8_W = 3;

   if (COL_W < BLK8_W || COL_W > 16) begin : g_col_chk
      $error("burst_col_seq: COL_W must lie in 3..16");
   end
   if (MODE_W != 13) begin : g_mode_chk
      $error("burst_col_seq: MODE_W must be 13");
   end

   bk_e              m_kind;
   logic             m_ilv;
   logic             m_wrs;
   logic             m_cl3;
   logic [COL_W-1:0] start_q;
   logic [COL_W-1:0] beat_q;
   bk_e              kind_q;
   logic             ilv_q;

   bcs_mode_reg #(.MW(MODE_W)) u_mode (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld        (mode_ld),
      .word      (mode_word),
      .kind      (m_kind),
      .ilv       (m_ilv),
      .wr_single (m_wrs),
      .cl3       (m_cl3),
      .err       (mode_err)
   );

   bcs_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
      .clk            (clk),
      .rst_n          (rst_n),
      .cmd_vld        (cmd_vld),
      .cmd_wr         (cmd_wr),
      .cmd_col        (cmd_col),
      .term           (burst_term),
      .mode_kind      (m_kind),
      .mode_ilv       (m_ilv),
      .mode_wr_single (m_wrs),
      .active         (col_vld),
      .last           (col_last),
      .start_q        (start_q),
      .beat_q         (beat_q),
      .kind_q         (kind_q),
      .ilv_q          (ilv_q)
   );

   bcs_addr_gen #(.COL_W(COL_W)) u_addr (
      .start (start_q),
      .beat  (beat_q),
      .kind  (kind_q),
      .ilv   (ilv_q),
      .col   (col_addr)
   );

   assign cas_lat = m_cl3 ? 2'd3 : 2'd2;

   // R3
   block_bits_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      col_vld && $past(col_vld) && !$past(cmd_vld) && kind_q != BK_PAGE
      |-> col_addr[COL_W-1:BLK8_W] == $past(col_addr[COL_W-1:BLK8_W]));

   // R12
   last_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      col_last |-> col_vld);

   // R6
   page_no_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      col_vld && kind_q == BK_PAGE |-> !col_last);

   // R7
   cas_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cas_lat == 2'd2 || cas_lat == 2'd3);

endmodule

// File: tb/sim_burst_col_seq.sv
`timescale 1ns/1ps
module sim_burst_col_seq;

   localparam int COL_W = 10;
   localparam int ROW   = 1 << COL_W;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             mode_ld = 1'b0;
   logic [12:0]      mode_word = '0;
   logic             cmd_vld = 1'b0;
   logic             cmd_wr = 1'b0;
   logic [COL_W-1:0] cmd_col = '0;
   logic             burst_term = 1'b0;
   logic [COL_W-1:0] col_addr;
   logic             col_vld;
   logic             col_last;
   logic             mode_err;
   logic [1:0]       cas_lat;

   always #2.5 clk = ~clk;

   burst_col_seq #(.COL_W(COL_W), .MODE_W(13)) u0 (
      .clk(clk), .rst_n(rst_n), .mode_ld(mode_ld), .mode_word(mode_word),
      .cmd_vld(cmd_vld), .cmd_wr(cmd_wr), .cmd_col(cmd_col),
      .burst_term(burst_term), .col_addr(col_addr), .col_vld(col_vld),
      .col_last(col_last), .mode_err(mode_err), .cas_lat(cas_lat)
   );

   int    checks = 0;
   int    fails = 0;
   bit    chk_en = 1'b0;
   bit    done = 1'b0;
   string phase = "R1";

   // reference model state (blen 0 = full page)
   int m_bl = 1, m_ilv = 0, m_wb = 0, m_cl = 2, m_err = 0;
   int b_act = 0, b_start = 0, b_beat = 0, b_len = 1, b_ilv = 0;

   function automatic logic [12:0] mw(int bl, int bt, int cl, int wb, int op, int hi);
      return {3'(hi), 1'(wb), 2'(op), 3'(cl), 1'(bt), 3'(bl)};
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_bl = 1; m_ilv = 0; m_wb = 0; m_cl = 2; m_err = 0; b_act = 0;
      end else begin
         // burst first: a command uses the settings held before this edge
         if (cmd_vld) begin
            b_act = 1; b_start = int'(cmd_col); b_beat = 0; b_ilv = m_ilv;
            b_len = (cmd_wr && m_wb == 1) ? 1 : m_bl;
         end else if (b_act == 1) begin
            if (burst_term || (b_len != 0 && b_beat == b_len - 1)) b_act = 0;
            else b_beat = (b_beat + 1) % ROW;
         end
         if (mode_ld) begin
            int bl, ok, cl;
            ok = 1; bl = 1; cl = 2;
            case (int'(mode_word[2:0]))
               0: bl = 1;
               1: bl = 2;
               2: bl = 4;
               3: bl = 8;
               7: begin bl = 0; if (mode_word[3]) ok = 0; end
               default: ok = 0;
            endcase
            if (mode_word[6:4] == 3'd2) cl = 2;
            else if (mode_word[6:4] == 3'd3) cl = 3;
            else ok = 0;
            if (mode_word[8:7] != 2'd0) ok = 0;
            m_err = (ok == 1) ? 0 : 1;
            if (ok == 1) begin
               m_bl = bl; m_cl = cl; m_ilv = int'(mode_word[3]); m_wb = int'(mode_word[9]);
            end
         end
      end
   end

   always @(negedge clk) begin
      if (chk_en && !done) begin
         int blk, off, o2, e_col, e_last;
         blk = (b_len == 0) ? ROW : b_len;
         off = b_start % blk;
         o2  = (b_ilv == 1 && b_len != 0) ? (off ^ b_beat) : ((off + b_beat) % blk);
         e_col  = b_start - off + o2;
         e_last = (b_act == 1 && b_len != 0 && b_beat == b_len - 1) ? 1 : 0;
         checks++;
         if (int'(col_vld) != b_act || int'(col_last) != e_last ||
             int'(mode_err) != m_err || int'(cas_lat) != m_cl ||
             (b_act == 1 && int'(col_addr) != e_col)) begin
            fails++;
            $display("FAIL %s t=%0t actual vld=%0d last=%0d col=%0d err=%0d cl=%0d expected vld=%0d last=%0d col=%0d err=%0d cl=%0d",
                     phase, $time, col_vld, col_last, col_addr, mode_err, cas_lat,
                     b_act, e_last, e_col, m_err, m_cl);
         end
      end
   end

   task automatic step(input bit ld, input logic [12:0] w, input bit cv,
                       input bit wr, input int c, input bit tm);
      @(posedge clk); #1;
      mode_ld = ld; mode_word = w; cmd_vld = cv; cmd_wr = wr;
      cmd_col = COL_W'(c); burst_term = tm;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, '0, 0, 0, 0, 0);
   endtask

   task automatic load(input logic [12:0] w);
      step(1, w, 0, 0, 0, 0);
   endtask

   task automatic rd(input int c);
      step(0, '0, 1, 0, c, 0);
   endtask

   task automatic wr(input int c);
      step(0, '0, 1, 1, c, 0);
   endtask

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !done) begin
         done = 1'b1;
         fails++;
         $display("FAIL watchdog actual cycles=%0d expected below 20000", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      @(posedge clk); #1;
      chk_en = 1'b1;
      phase = "R1";
      idle(3);
      rst_n = 1'b1;
      idle(3);

      phase = "R5";
      rd(37); idle(3);
      load(mw(0, 1, 2, 0, 0, 0)); rd(38); idle(3);

      phase = "R2";
      load(mw(1, 0, 2, 0, 0, 0)); rd(12'h0f3); idle(4);
      load(mw(2, 0, 2, 0, 0, 0)); rd(6); idle(6);

      phase = "R3";
      load(mw(3, 0, 3, 0, 0, 0)); rd(12'h105); idle(10);
      rd(12'h3ff); idle(10);
      load(mw(2, 0, 3, 0, 0, 0)); rd(12'h2a); idle(6);

      phase = "R7";
      load(mw(3, 0, 2, 0, 0, 0)); idle(2);
      load(mw(3, 0, 3, 0, 0, 0)); idle(2);

      phase = "R4";
      load(mw(3, 1, 2, 0, 0, 0)); rd(5); idle(10);
      rd(12'h1ea); idle(10);
      load(mw(2, 1, 2, 0, 0, 0)); rd(12'h0e); idle(6);
      load(mw(1, 1, 2, 0, 0, 0)); rd(12'h21); idle(4);

      phase = "R6";
      load(mw(7, 0, 2, 0, 0, 0)); rd(1020); idle(12);
      step(0, '0, 0, 0, 0, 1); idle(3);
      rd(3); idle(20); rd(500); idle(5);
      step(0, '0, 0, 0, 0, 1); idle(3);

      phase = "R11";
      step(0, '0, 0, 0, 0, 1); idle(2);
      load(mw(3, 0, 2, 0, 0, 0)); rd(12'h44); idle(2);
      step(0, '0, 0, 0, 0, 1); idle(3);
      rd(12'h50); idle(1);
      step(0, '0, 1, 0, 12'h63, 1); idle(10);

      phase = "R10";
      rd(12'h10); idle(3); rd(12'h77); idle(1); rd(12'h81); idle(10);

      phase = "R12";
      load(mw(1, 0, 2, 0, 0, 0)); rd(12'h11); rd(12'h20); rd(12'h31); idle(3);
      load(mw(3, 0, 2, 0, 0, 0)); rd(12'h08); idle(6); rd(12'h0c); idle(10);

      phase = "R9";
      load(mw(3, 1, 2, 1, 0, 0)); wr(12'h35); idle(3);
      rd(12'h35); idle(10);
      load(mw(7, 0, 2, 1, 0, 0)); wr(12'h99); idle(3);
      load(mw(3, 0, 2, 0, 0, 0)); wr(12'h9a); idle(10);

      phase = "R8";
      load(mw(4, 0, 2, 0, 0, 0)); idle(2); rd(12'h12); idle(10);
      load(mw(5, 0, 3, 0, 0, 0)); idle(2);
      load(mw(6, 0, 3, 0, 0, 0)); idle(2);
      load(mw(7, 1, 3, 0, 0, 0)); idle(2);
      load(mw(2, 0, 0, 0, 0, 0)); idle(2);
      load(mw(2, 0, 1, 0, 0, 0)); idle(2);
      load(mw(2, 0, 4, 0, 0, 0)); idle(2);
      load(mw(2, 0, 3, 0, 1, 0)); idle(2);
      load(mw(2, 0, 3, 0, 2, 0)); idle(2);
      rd(12'h13); idle(10);
      load(mw(2, 1, 3, 0, 0, 7)); idle(2); rd(12'h17); idle(6);

      phase = "R13";
      load(mw(3, 0, 2, 0, 0, 0)); idle(1);
      step(1, mw(1, 1, 2, 0, 0, 0), 1, 0, 12'h46, 0); idle(10);
      rd(12'h46); idle(2);
      load(mw(7, 0, 3, 0, 0, 0)); idle(8);
      step(1, mw(2, 0, 2, 1, 0, 0), 1, 1, 12'h2e, 0); idle(8);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule